// File: doc/BRIEF.md
# Test Pattern Source and Receive Checker

This block produces a stream of 64-bit test words for an external transmit FIFO and checks the words that an external receive FIFO delivers. Both sides use one clock. Each word holds two consecutive 32-bit values taken from a running word counter. The transmit side writes words until a programmed number of words has gone out. The receive side reads a word whenever one is available. It rebuilds the value it expects from its own counter and, when checking is enabled, records any difference in a sticky error flag.

Software reaches the block through a simple word-addressed register port. A write takes effect at once. A read request returns data one cycle later with a valid strobe. The two low address bits select one of four registers, and all higher address bits must be zero:

- Index 0 holds the transmit size.
- Index 1 is the command.
- Index 2 is the soft reset.
- Index 3 is the receive count.

Top module: `patt_gen_chk`

## Requirements
- R1: After reset, txWrEn is 0, command read bits [1:0] are 0, and the reads of index 0 and index 3 both return 0.
- R2: A write to index 0 sets the transmit size in 64-bit words and does not start a transfer. A read of index 0 returns the number of words written to the transmit FIFO since the last clear.
- R3: A write to index 1 with bit 0 equal to 0 starts a transfer when the size is nonzero. Command read bit 0 (busy) is then 1 until the transfer ends.
- R4: txWrEn is 0 in every cycle in which txFull is 1.
- R5: Word n of a transfer, counting from 0, carries 2n in bits [31:0] and 2n+1 in bits [63:32], each modulo 2^32.
- R6: A transfer writes exactly the programmed number of words and then clears busy.
- R7: rxRdEn is the inverse of rxEmpty. Read data is taken one cycle after the read.
- R8: The receive count (index 3) rises by one for each word read, whether or not checking is enabled.
- R9: When command bit 1 was written as 1, a received word that differs from the R5 pattern for its position sets the sticky error flag, which is command read bit 1. When bit 1 was written as 0, mismatches leave the flag at 0.
- R10: Any write to index 1 clears both counts and the error flag. If a count step falls in the same cycle as that write, the clear wins, and the next transmit word is word 0 again.
- R11: A write to index 2 with bit 0 set returns all logic to the reset state, stopping any transfer. A read of index 2 returns 0.
- R12: A command write with bit 0 set, or a start while the size is 0, leaves busy at 0 and writes no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regRdReq | input | 1 | Register read request |
| regAddr | input | ADDR_W | Register word address |
| regWrData | input | REG_W | Register write data |
| regRdData | output | REG_W | Register read data |
| regRdValid | output | 1 | Read data valid, one cycle after the request |
| txFull | input | 1 | Transmit FIFO full |
| txWrEn | output | 1 | Transmit FIFO write enable |
| txWrData | output | 64 | Transmit FIFO write data |
| rxEmpty | input | 1 | Receive FIFO empty |
| rxRdEn | output | 1 | Receive FIFO read enable |
| rxRdData | input | 64 | Receive FIFO read data, valid one cycle after the read |

## Verification
A command write can fall in the same cycle as a transmit word leaving the block or as a received word being counted. In that case the clear must win over the count step. The bench restarts a running transfer while words are flowing with no backpressure. It then judges, word by word, that the word accepted in the restart cycle still carries its old index and that the following word is word 0. The receive side is judged on its count and error flag after sticky mismatches have been followed by a clearing command write.

// File: rtl/patt_pkg.sv
package patt_pkg;
  localparam int PATT_W = 32;
  localparam int DATA_W = 2 * PATT_W;

  typedef struct packed {
    logic loadSize;
    logic clrCnt;
    logic start;
    logic verifyVal;
    logic softRst;
  } ctrlStrb_t;

  function automatic logic [DATA_W-1:0] pattWord(input logic [PATT_W-1:0] idx);
    logic [PATT_W-1:0] lo;
    lo = idx << 1;
    return {lo | PATT_W'(1), lo};
  endfunction
endpackage

// File: rtl/patt_ctrl.sv
module patt_ctrl
  import patt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int REG_W  = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic              regRdReq,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              regRdValid,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              busy,
  input  logic              errFlag,
  output ctrlStrb_t         strb
);
  localparam int IDX_W = 2;

  logic             hit;
  logic [IDX_W-1:0] idx;

  assign idx = regAddr[IDX_W-1:0];
  assign hit = (regAddr[ADDR_W-1:IDX_W] == '0);

  always_comb begin
    strb           = '0;
    strb.verifyVal = regWrData[1];
    if (regWrEn && hit) begin
      strb.loadSize = (idx == 2'd0);
      strb.clrCnt   = (idx == 2'd1);
      strb.start    = (idx == 2'd1) && !regWrData[0];
      strb.softRst  = (idx == 2'd2) && regWrData[0];
    end
  end

  logic [REG_W-1:0] rdMux;

  always_comb begin
    rdMux = '0;
    if (hit) begin
      unique case (idx)
        2'd0:    rdMux = REG_W'(txCount);
        2'd1:    rdMux = REG_W'({errFlag, busy});
        2'd3:    rdMux = REG_W'(rxCount);
        default: rdMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regRdValid <= 1'b0;
      regRdData  <= '0;
    end else begin
      regRdValid <= regRdReq;
      if (regRdReq) regRdData <= rdMux;
    end
  end
endmodule

// File: rtl/patt_dpath.sv
module patt_dpath
  import patt_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrb_t         strb,
  input  logic [REG_W-1:0]  sizeIn,
  input  logic              txFull,
  output logic              txWrEn,
  output logic [DATA_W-1:0] txWrData,
  input  logic              rxEmpty,
  output logic              rxRdEn,
  input  logic [DATA_W-1:0] rxRdData,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount,
  output logic [CNT_W-1:0]  txSize,
  output logic              busy,
  output logic              errFlag
);
  logic txActive;
  logic verifyEn;
  logic rdEnD;
  logic [DATA_W-1:0] expWord;
  logic [CNT_W-1:0]  txNext;

  assign txWrEn   = txActive && !txFull;
  assign txWrData = pattWord(PATT_W'(txCount));
  assign rxRdEn   = !rxEmpty;
  assign expWord  = pattWord(PATT_W'(rxCount));
  assign txNext   = txCount + CNT_W'(1);
  assign busy     = txActive;

  always_ff @(posedge clk) begin
    if (rst || strb.softRst) begin
      txSize   <= '0;
      txCount  <= '0;
      rxCount  <= '0;
      txActive <= 1'b0;
      verifyEn <= 1'b0;
      errFlag  <= 1'b0;
      rdEnD    <= 1'b0;
    end else begin
      rdEnD <= rxRdEn;
      if (strb.loadSize) txSize <= CNT_W'(sizeIn);
      if (strb.clrCnt) begin
        txCount  <= '0;
        rxCount  <= '0;
        errFlag  <= 1'b0;
        verifyEn <= strb.verifyVal;
        txActive <= strb.start && (txSize != '0);
      end else begin
        if (txWrEn) begin
          txCount <= txNext;
          if (txNext == txSize) txActive <= 1'b0;
        end
        if (rdEnD) begin
          rxCount <= rxCount + CNT_W'(1);
          if (verifyEn && (rxRdData != expWord)) errFlag <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/patt_gen_chk.sv
module patt_gen_chk
  import patt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int REG_W  = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic              regRdReq,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              regRdValid,
  input  logic              txFull,
  output logic              txWrEn,
  output logic [63:0]       txWrData,
  input  logic              rxEmpty,
  output logic              rxRdEn,
  input  logic [63:0]       rxRdData
);
  ctrlStrb_t        strb;
  logic [CNT_W-1:0] txCount;
  logic [CNT_W-1:0] rxCount;
  logic [CNT_W-1:0] txSize;
  logic             busy;
  logic             errFlag;

  patt_ctrl #(.ADDR_W(ADDR_W), .REG_W(REG_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdReq(regRdReq),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .regRdValid(regRdValid), .txCount(txCount), .rxCount(rxCount),
    .busy(busy), .errFlag(errFlag), .strb(strb)
  );

  patt_dpath #(.REG_W(REG_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .sizeIn(regWrData),
    .txFull(txFull), .txWrEn(txWrEn), .txWrData(txWrData),
    .rxEmpty(rxEmpty), .rxRdEn(rxRdEn), .rxRdData(rxRdData),
    .txCount(txCount), .rxCount(rxCount), .txSize(txSize),
    .busy(busy), .errFlag(errFlag)
  );
endmodule

// File: rtl/patt_gen_chk_sva.sv
module patt_gen_chk_sva #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic              txFull,
  input logic              txWrEn,
  input logic [CNT_W-1:0]  txCount,
  input logic [CNT_W-1:0]  rxCount,
  input logic [CNT_W-1:0]  txSize,
  input logic              busy,
  input logic              errFlag
);
  logic cmdWr, rstWr;
  assign cmdWr = regWrEn && (regAddr == ADDR_W'(1));
  assign rstWr = regWrEn && (regAddr == ADDR_W'(2)) && regWrData[0];

  assert_full_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    txFull |-> !txWrEn);

  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    (!cmdWr && !rstWr) |=> (rxCount == $past(rxCount)) || (rxCount == $past(rxCount) + CNT_W'(1)));

  assert_busy_below_size_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !cmdWr && !rstWr) |-> (txCount < txSize));

  assert_cmd_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (cmdWr && !rstWr) |=> (txCount == '0) && (rxCount == '0) && !errFlag);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (errFlag && !cmdWr && !rstWr) |=> errFlag);

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (rst)
    rstWr |=> !busy && (txCount == '0) && (rxCount == '0));
endmodule

bind patt_gen_chk patt_gen_chk_sva #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData[31:0]), .txFull(txFull), .txWrEn(txWrEn),
  .txCount(txCount), .rxCount(rxCount), .txSize(txSize),
  .busy(busy), .errFlag(errFlag)
);

// File: tb/patt_gen_chk_bench.sv
`timescale 1ns/1ps
module patt_gen_chk_bench;
  logic clk = 0;
  logic rst = 1;
  logic regWrEn = 0, regRdReq = 0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic regRdValid;
  logic txFull = 0;
  logic txWrEn;
  logic [63:0] txWrData;
  logic rxEmpty;
  logic rxRdEn;
  logic [63:0] rxRdData = '0;

  int checks = 0, errors = 0;
  int expIdx = 0, txCap = 0;
  int fullMode = 0;
  logic [63:0] mem [0:255];
  int wrPtr = 0, rdPtr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  patt_gen_chk u_patt_gen_chk (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdReq(regRdReq),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .regRdValid(regRdValid), .txFull(txFull), .txWrEn(txWrEn),
    .txWrData(txWrData), .rxEmpty(rxEmpty), .rxRdEn(rxRdEn),
    .rxRdData(rxRdData)
  );

  function automatic logic [63:0] expPatt(input int n);
    logic [31:0] a;
    a = 32'(2 * n);
    return {a + 32'd1, a};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  assign rxEmpty = (rdPtr == wrPtr);
  always @(posedge clk) begin
    txFull <= (fullMode != 0) && ($urandom_range(0, 2) == 0);
    if (rxRdEn) begin
      rxRdData <= mem[rdPtr % 256];
      rdPtr <= rdPtr + 1;
    end
  end

  always @(negedge clk) if (!rst) begin
    if (txFull) check(!txWrEn, "R4", longint'(txWrEn), 0);
    if (rxRdEn == rxEmpty) check(0, "R7", longint'(rxRdEn), longint'(!rxEmpty));
    if (txWrEn) begin
      check(txWrData == expPatt(expIdx), "R5", txWrData, expPatt(expIdx));
      expIdx++;
      txCap++;
    end
    if (regWrEn && regAddr == 4'd1) begin expIdx = 0; txCap = 0; end
    if (regWrEn && regAddr == 4'd2 && regWrData[0]) begin expIdx = 0; txCap = 0; end
  end

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    regRdReq = 1; regAddr = a;
    @(posedge clk); #1;
    regRdReq = 0;
    d = regRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      regRead(4'd1, v);
      if (!v[0]) break;
    end
  endtask

  task automatic pushWord(input logic [63:0] d);
    mem[wrPtr % 256] = d;
    wrPtr++;
  endtask

  task automatic drain();
    while (rdPtr != wrPtr) begin @(posedge clk); #1; end
    repeat (3) begin @(posedge clk); #1; end
  endtask

  initial begin
    logic [31:0] v;
    int unsigned seed;
    int n;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(posedge clk); #1;

    check(!txWrEn, "R1", longint'(txWrEn), 0);
    regRead(4'd1, v); check(v[1:0] == 2'b00, "R1", v, 0);
    regRead(4'd0, v); check(v == 0, "R1", v, 0);
    regRead(4'd3, v); check(v == 0, "R1", v, 0);

    regWrite(4'd0, 32'd20);
    regRead(4'd1, v); check(v[0] == 1'b0, "R2", v, 0);
    regRead(4'd0, v); check(v == 0, "R2", v, 0);

    fullMode = 1;
    regWrite(4'd1, 32'd0);
    regRead(4'd1, v); check(v[0] == 1'b1, "R3", v, 1);
    waitIdle();
    regRead(4'd0, v); check(v == 20, "R2", v, 20);
    check(txCap == 20, "R6", txCap, 20);

    for (int k = 0; k < 3; k++) begin
      n = $urandom_range(1, 40);
      regWrite(4'd0, 32'(n));
      regWrite(4'd1, 32'd0);
      waitIdle();
      check(txCap == n, "R6", txCap, n);
    end
    fullMode = 0;

    regWrite(4'd0, 32'd1);
    regWrite(4'd1, 32'd0);
    waitIdle();
    check(txCap == 1, "R6", txCap, 1);

    regWrite(4'd0, 32'd0);
    regWrite(4'd1, 32'd0);
    repeat (10) @(posedge clk); #1;
    regRead(4'd1, v); check(v[0] == 1'b0, "R12", v, 0);
    check(txCap == 0, "R12", txCap, 0);
    regWrite(4'd0, 32'd5);
    regWrite(4'd1, 32'd1);
    repeat (10) @(posedge clk); #1;
    check(txCap == 0, "R12", txCap, 0);

    regWrite(4'd1, 32'd3);
    n = $urandom_range(10, 60);
    for (int i = 0; i < n; i++) begin
      pushWord(expPatt(i));
      if ($urandom_range(0, 3) == 0) begin @(posedge clk); #1; end
    end
    drain();
    regRead(4'd3, v); check(v == 32'(n), "R8", v, n);
    regRead(4'd1, v); check(v[1] == 1'b0, "R9", v, 0);

    pushWord(expPatt(n) ^ 64'h100);
    for (int i = n + 1; i < n + 6; i++) pushWord(expPatt(i));
    drain();
    regRead(4'd1, v); check(v[1] == 1'b1, "R9", v, 2);
    regRead(4'd3, v); check(v == 32'(n + 6), "R8", v, n + 6);

    regWrite(4'd1, 32'd3);
    regRead(4'd1, v); check(v[1] == 1'b0, "R10", v, 0);
    regRead(4'd3, v); check(v == 0, "R10", v, 0);

    regWrite(4'd1, 32'd1);
    pushWord(64'hdead_beef_0bad_f00d);
    pushWord(expPatt(1));
    drain();
    regRead(4'd1, v); check(v[1] == 1'b0, "R9", v, 0);
    regRead(4'd3, v); check(v == 2, "R8", v, 2);

    regWrite(4'd0, 32'd50);
    regWrite(4'd1, 32'd0);
    repeat (10) @(posedge clk); #1;
    regWrite(4'd1, 32'd0);
    waitIdle();
    check(txCap == 50, "R10", txCap, 50);
    regRead(4'd0, v); check(v == 50, "R10", v, 50);

    regWrite(4'd0, 32'd1000);
    regWrite(4'd1, 32'd0);
    repeat (15) @(posedge clk); #1;
    regWrite(4'd2, 32'd1);
    regRead(4'd1, v); check(v[0] == 1'b0, "R11", v, 0);
    regRead(4'd0, v); check(v == 0, "R11", v, 0);
    regRead(4'd2, v); check(v == 0, "R11", v, 0);
    check(txCap == 0, "R11", txCap, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule